// File: doc/BRIEF.md
# Double-Buffered SPI Transfer Engine

This block is an SPI port that works either as the bus master or as a slave. A one-byte holding register sits in front of the shift register, so software can queue the next byte while the current one is still on the wire. A receive register behind the shift register keeps the last completed byte until software collects it. The software side is a small register interface: one data register and one status register, selected by a single address bit.

In master mode the block makes the serial clock with a selectable divider and supports all four clock polarity and phase combinations. While a byte is being shifted, it drives its select output low. A queued byte follows the previous one with no idle gap. In slave mode the serial clock, data and select inputs are synchronised to the bus clock. The shift register can only be reloaded while the select is inactive or at the end of a byte. If nothing new was queued, the byte left in the shift register goes out again. Two interrupt request outputs, each gated by its own enable input, report transmit-empty and receive-full.

Top module: `spi_dbuf_port`

## Requirements
- R1: After reset the status register reads 0x01. The status register is at address 1, the data register at address 0. Status bit 0 is transmit-empty, bit 1 is receive-full, bit 2 is overrun, and the upper bits read 0. After reset the master select output is high and the serial clock sits at the polarity level.
- R2: A write to the data register clears transmit-empty in the next cycle. If the shift register is idle, the byte moves into it and transmit-empty is set again two cycles after the write.
- R3: In master mode the byte is shifted most-significant bit first. The byte received on MISO matches what was presented at the sampling edges, for every polarity/phase combination.
- R4: In master mode, divider select 0, 1, 2 and 3 gives a serial clock of bus/2, bus/8, bus/16 and bus/32. The select output stays low for exactly 16 half-periods per byte. Between transfers the serial clock rests at the polarity level.
- R5: In master mode a byte waiting at the end of a transfer starts at once. The select output stays low with no gap, and transmit-empty sets at the completion edge.
- R6: In slave mode, while the select input is active, a queued byte stays in the holding register and transmit-empty stays 0 until the current byte completes.
- R7: In slave mode, if no byte is queued when a new byte starts, the shift register contents are sent again. After a completed byte, those contents are the byte just received.
- R8: At the end of every byte the received byte goes to the data register and receive-full is set.
- R9: Receive-full is cleared only by a data read that follows a status read which saw receive-full set. A data read alone leaves it set.
- R10: A byte that completes while receive-full is set sets overrun and leaves the data register unchanged. The clearing sequence of R9 clears overrun as well.
- R11: The transmit interrupt output equals transmit-empty AND its enable input. The receive interrupt output equals receive-full AND its enable input.
- R12: In slave mode the block shifts MSB first on MISO and receives MOSI correctly in all four modes, including phase 1 / polarity 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_master | input | 1 | 1 = master, 0 = slave |
| cfg_cpol | input | 1 | Serial clock idle level |
| cfg_cpha | input | 1 | 0 = sample on leading edge, 1 = sample on trailing edge |
| cfg_div | input | 2 | Master clock divider select |
| cfg_txie | input | 1 | Transmit interrupt enable |
| cfg_rxie | input | 1 | Receive interrupt enable |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 1 | 0 = data, 1 = status |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data (combinational) |
| sclk_o | output | 1 | Serial clock out (master) |
| sclk_i | input | 1 | Serial clock in (slave) |
| mosi_o | output | 1 | Serial data out (master) |
| mosi_i | input | 1 | Serial data in (slave) |
| miso_o | output | 1 | Serial data out (slave) |
| miso_i | input | 1 | Serial data in (master) |
| ss_n_o | output | 1 | Select output, low while the master shifts |
| ss_n_i | input | 1 | Select input (slave), active low |
| irq_tx | output | 1 | Transmit-empty interrupt request |
| irq_rx | output | 1 | Receive-full interrupt request |

## Verification
The master path is swept over all sixteen combinations of polarity, phase and divider, with a different byte for each and MOSI looped back to MISO. A bench monitor captures MOSI at the sampling edges and counts select-low cycles, which separates a bit-order fault from a phase fault and a wrong divide ratio from a dropped edge. Two-byte runs separate a seamless follow-on from a restarted transfer, and show overrun when the first byte is left unread. The slave path is driven in all four modes by a bench-side master that writes a byte mid-transfer and then sends a third byte with nothing queued, which exposes early reloads and a wrong resend value.

// File: rtl/spi_dbuf_pkg.sv
// Shared constants for the double-buffered SPI port.
// Assumes one address bit selects data (0) or status (1).
package spi_dbuf_pkg;
    localparam int ST_TXE = 0;  // status bit: holding register free
    localparam int ST_RXF = 1;  // status bit: received byte waiting
    localparam int ST_OVR = 2;  // status bit: byte lost to a full receiver
    localparam int MAX_HALF = 16; // largest half-period in bus clocks

    // Half-period of the master serial clock for a divider select code.
    function automatic int half_period(input logic [1:0] sel);
        case (sel)
            2'd0:    return 1;
            2'd1:    return 4;
            2'd2:    return 8;
            default: return 16;
        endcase
    endfunction
endpackage

// File: rtl/spi_dbuf_sync.sv
// Two-stage synchronisers for the slave-side pins, plus clock edge detection.
// Assumes the external serial clock is slower than a quarter of the bus clock.
module spi_dbuf_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic sclk_i,
    input  logic mosi_i,
    input  logic ss_n_i,
    output logic s_mosi,
    output logic s_ss_n,
    output logic s_edge
);
    logic [1:0] sclk_q, mosi_q, ss_q;
    logic       sclk_d;

    // Synchronise the pins and remember the previous clock level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sclk_q <= '0;
            mosi_q <= '0;
            ss_q   <= 2'b11;
            sclk_d <= 1'b0;
        end else begin
            sclk_q <= {sclk_q[0], sclk_i};
            mosi_q <= {mosi_q[0], mosi_i};
            ss_q   <= {ss_q[0], ss_n_i};
            sclk_d <= sclk_q[1];
        end
    end

    assign s_mosi = mosi_q[1];
    assign s_ss_n = ss_q[1];
    assign s_edge = (sclk_q[1] != sclk_d) && !ss_q[1];
endmodule

// File: rtl/spi_dbuf_clkgen.sv
// Master serial clock generator: toggles the clock once every half-period
// while run is high and rests at the polarity level otherwise.
// Assumes the divider select stays constant during a transfer.
module spi_dbuf_clkgen
    import spi_dbuf_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run,
    input  logic [1:0] div_sel,
    input  logic       cpol,
    output logic       tick,
    output logic       sclk
);
    localparam int CNT_W = $clog2(MAX_HALF);

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] lim;

    assign lim  = CNT_W'(half_period(div_sel) - 1);
    assign tick = run && (cnt == lim);

    // Count bus clocks in the half-period and toggle the clock at its end.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt  <= '0;
            sclk <= cpol;
        end else if (cnt == lim) begin
            cnt  <= '0;
            sclk <= ~sclk;
        end else begin
            cnt  <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/spi_dbuf_shifter.sv
// Shift engine shared by master and slave. It handles one clock edge per
// strobe, samples on the phase-selected edge and shifts on the other. It
// reports each finished byte and pulls the holding register in when that
// is allowed. Assumes edge strobes arrive only inside a transfer.
module spi_dbuf_shifter #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              master,
    input  logic              cpha,
    input  logic              edge_stb,
    input  logic              ss_idle,
    input  logic              in_bit,
    input  logic              hold_full,
    input  logic [DATA_W-1:0] hold_data,
    output logic              take,
    output logic              busy,
    output logic              done,
    output logic [DATA_W-1:0] done_data,
    output logic              tx_bit
);
    localparam int EDGES = 2 * DATA_W;
    localparam int EW    = $clog2(EDGES);

    logic [DATA_W-1:0] sh;
    logic [EW-1:0]     ecnt;
    logic              sbit;
    logic              lead, last, samp;

    assign lead      = ~ecnt[0];
    assign last      = (ecnt == EW'(EDGES - 1));
    assign samp      = lead ^ cpha;
    assign done      = edge_stb && last;
    assign done_data = {sh[DATA_W-2:0], cpha ? in_bit : sbit};
    assign take      = hold_full && (master ? (!busy || done) : (ss_idle || done));
    assign tx_bit    = sh[DATA_W-1];

    // Edge handling, byte completion and holding-register reloads.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh   <= '0;
            ecnt <= '0;
            sbit <= 1'b0;
            busy <= 1'b0;
        end else begin
            if (edge_stb) begin
                ecnt <= last ? '0 : ecnt + 1'b1;
                if (samp)
                    sbit <= in_bit;
                if (last)
                    sh <= done_data;
                else if (!samp && !(cpha && ecnt == '0))
                    sh <= {sh[DATA_W-2:0], sbit};
            end
            if (!master && ss_idle)
                ecnt <= '0;
            if (take)
                sh <= hold_data;
            if (!master)
                busy <= 1'b0;
            else if (take)
                busy <= 1'b1;
            else if (done)
                busy <= 1'b0;
        end
    end
endmodule

// File: rtl/spi_dbuf_regs.sv
// Register side: the holding register, the receive register, the status
// flags, the status-then-data clearing sequence and the interrupt requests.
// Assumes read and write strobes last one bus clock each.
module spi_dbuf_regs
    import spi_dbuf_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic              bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              cfg_txie,
    input  logic              cfg_rxie,
    input  logic              take,
    input  logic              done,
    input  logic [DATA_W-1:0] done_data,
    output logic [DATA_W-1:0] hold_data,
    output logic              hold_full,
    output logic              tx_empty,
    output logic              rx_full,
    output logic              overrun,
    output logic [DATA_W-1:0] rx_data,
    output logic              armed,
    output logic              irq_tx,
    output logic              irq_rx
);
    logic wr_data, rd_data, rd_stat, clr, full_eff;
    logic [DATA_W-1:0] status;

    assign wr_data  = bus_wr && !bus_addr;
    assign rd_data  = bus_rd && !bus_addr;
    assign rd_stat  = bus_rd && bus_addr;
    assign clr      = rd_data && armed;
    assign full_eff = rx_full && !clr;
    assign tx_empty = !hold_full;
    assign irq_tx   = cfg_txie && tx_empty;
    assign irq_rx   = cfg_rxie && rx_full;

    // Holding register: a CPU write fills it, the shift engine drains it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_full <= 1'b0;
            hold_data <= '0;
        end else begin
            if (take)
                hold_full <= 1'b0;
            if (wr_data) begin
                hold_data <= bus_wdata;
                hold_full <= 1'b1;
            end
        end
    end

    // Receive register, overrun and the two-step clearing sequence.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_full <= 1'b0;
            overrun <= 1'b0;
            armed   <= 1'b0;
            rx_data <= '0;
        end else begin
            if (clr) begin
                rx_full <= 1'b0;
                overrun <= 1'b0;
                armed   <= 1'b0;
            end
            if (rd_stat && rx_full)
                armed <= 1'b1;
            if (done) begin
                if (full_eff)
                    overrun <= 1'b1;
                else begin
                    rx_data <= done_data;
                    rx_full <= 1'b1;
                end
            end
        end
    end

    // Read multiplexer for the data and status registers.
    always_comb begin
        status          = '0;
        status[ST_TXE]  = tx_empty;
        status[ST_RXF]  = rx_full;
        status[ST_OVR]  = overrun;
        bus_rdata       = bus_addr ? status : rx_data;
    end
endmodule

// File: rtl/spi_dbuf_port.sv
// Top of the double-buffered SPI port. It picks the edge source (internal
// divider as master, synchronised pins as slave) and the serial input,
// and connects the shift engine to the register side.
// Assumes the configuration inputs change only while the port is idle.
module spi_dbuf_port #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_master,
    input  logic              cfg_cpol,
    input  logic              cfg_cpha,
    input  logic [1:0]        cfg_div,
    input  logic              cfg_txie,
    input  logic              cfg_rxie,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic              bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              sclk_o,
    input  logic              sclk_i,
    output logic              mosi_o,
    input  logic              mosi_i,
    output logic              miso_o,
    input  logic              miso_i,
    output logic              ss_n_o,
    input  logic              ss_n_i,
    output logic              irq_tx,
    output logic              irq_rx
);
    logic s_mosi, s_ss_n, s_edge, tick, sclk_r;
    logic edge_stb, in_bit, take, busy, done, tx_bit;
    logic hold_full, tx_empty, rx_full, overrun, armed;
    logic [DATA_W-1:0] hold_data, done_data, rx_data;

    spi_dbuf_sync u_sync (
        .clk(clk), .rst_n(rst_n), .sclk_i(sclk_i), .mosi_i(mosi_i),
        .ss_n_i(ss_n_i), .s_mosi(s_mosi), .s_ss_n(s_ss_n), .s_edge(s_edge)
    );

    spi_dbuf_clkgen u_clkgen (
        .clk(clk), .rst_n(rst_n), .run(cfg_master && busy),
        .div_sel(cfg_div), .cpol(cfg_cpol), .tick(tick), .sclk(sclk_r)
    );

    assign edge_stb = cfg_master ? tick : s_edge;
    assign in_bit   = cfg_master ? miso_i : s_mosi;

    spi_dbuf_shifter #(.DATA_W(DATA_W)) u_shift (
        .clk(clk), .rst_n(rst_n), .master(cfg_master), .cpha(cfg_cpha),
        .edge_stb(edge_stb), .ss_idle(s_ss_n), .in_bit(in_bit),
        .hold_full(hold_full), .hold_data(hold_data), .take(take),
        .busy(busy), .done(done), .done_data(done_data), .tx_bit(tx_bit)
    );

    spi_dbuf_regs #(.DATA_W(DATA_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .cfg_txie(cfg_txie), .cfg_rxie(cfg_rxie), .take(take), .done(done),
        .done_data(done_data), .hold_data(hold_data), .hold_full(hold_full),
        .tx_empty(tx_empty), .rx_full(rx_full), .overrun(overrun),
        .rx_data(rx_data), .armed(armed), .irq_tx(irq_tx), .irq_rx(irq_rx)
    );

    assign sclk_o = sclk_r;
    assign mosi_o = cfg_master && tx_bit;
    assign miso_o = !cfg_master && !s_ss_n && tx_bit;
    assign ss_n_o = !(cfg_master && busy);
endmodule

// File: rtl/spi_dbuf_port_chk.sv
// Property checker for spi_dbuf_port, attached with bind below.
// Observes flags from the register side against events from the shift engine.
module spi_dbuf_port_chk #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_master,
    input logic              cfg_cpol,
    input logic              bus_wr,
    input logic              bus_rd,
    input logic              bus_addr,
    input logic              sclk_o,
    input logic              ss_n_o,
    input logic              s_ss_n,
    input logic              done,
    input logic              tx_empty,
    input logic              rx_full,
    input logic              overrun,
    input logic              armed,
    input logic [DATA_W-1:0] rx_data
);
    // R2: a data write leaves the holding register occupied next cycle
    assert_txe_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && !bus_addr) |=> !tx_empty);

    // R4: an idle master rests the serial clock at the polarity level
    assert_sclk_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_master && ss_n_o && $stable(cfg_cpol)) |-> (sclk_o == cfg_cpol));

    // R5: a byte waiting at completion keeps the master select low
    assert_no_gap_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_master && done && !tx_empty) |=> !ss_n_o);

    // R6: an active slave does not drain the holding register mid-byte
    assert_slave_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_master && !s_ss_n && !tx_empty && !done) |=> !tx_empty);

    // R9: receive-full only falls after a data read
    assert_rxf_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rx_full) |-> $past(bus_rd && !bus_addr));

    // R10: a byte finishing into a full receiver flags overrun, keeps data
    assert_overrun_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (done && rx_full && !(bus_rd && !bus_addr && armed))
        |=> (overrun && $stable(rx_data)));
endmodule

bind spi_dbuf_port spi_dbuf_port_chk #(.DATA_W(DATA_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .cfg_master(cfg_master), .cfg_cpol(cfg_cpol),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr), .sclk_o(sclk_o),
    .ss_n_o(ss_n_o), .s_ss_n(s_ss_n), .done(done), .tx_empty(tx_empty),
    .rx_full(rx_full), .overrun(overrun), .armed(armed), .rx_data(rx_data)
);

// File: tb/spi_dbuf_port_tb.sv
// Bench for spi_dbuf_port: master sweep with loopback, two-byte runs,
// clearing and interrupt checks, and a bench-driven master for slave mode.
module spi_dbuf_port_tb;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_master = 1'b1, cfg_cpol = 1'b0, cfg_cpha = 1'b0;
    logic [1:0] cfg_div = 2'd0;
    logic cfg_txie = 1'b1, cfg_rxie = 1'b1;
    logic bus_wr = 1'b0, bus_rd = 1'b0, bus_addr = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic sclk_o, mosi_o, miso_o, ss_n_o, irq_tx, irq_rx, miso_i;
    logic sclk_i = 1'b0, mosi_i = 1'b0, ss_n_i = 1'b1;

    int checks = 0, errors = 0, cyc = 0;
    bit finished = 0;
    localparam int H = 8;

    always #2 clk = ~clk;

    assign miso_i = mosi_o;

    spi_dbuf_port u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_master(cfg_master), .cfg_cpol(cfg_cpol),
        .cfg_cpha(cfg_cpha), .cfg_div(cfg_div), .cfg_txie(cfg_txie),
        .cfg_rxie(cfg_rxie), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .sclk_o(sclk_o), .sclk_i(sclk_i), .mosi_o(mosi_o), .mosi_i(mosi_i),
        .miso_o(miso_o), .miso_i(miso_i), .ss_n_o(ss_n_o), .ss_n_i(ss_n_i),
        .irq_tx(irq_tx), .irq_rx(irq_rx)
    );

    // Monitor: MOSI captured just before each sampling edge, select-low cycles, select rises.
    logic [7:0] cap = '0;
    int lowcnt = 0, rises = 0;
    logic prev_sclk = 1'b0, prev_mosi = 1'b0, prev_ss = 1'b1, clr_mon = 1'b0;
    always @(negedge clk) begin
        if (clr_mon) begin
            cap <= '0; lowcnt <= 0; rises <= 0;
        end else begin
            if (sclk_o != prev_sclk && ((prev_sclk == cfg_cpol) ^ cfg_cpha))
                cap <= {cap[6:0], prev_mosi};
            if (!ss_n_o) lowcnt <= lowcnt + 1;
            if (ss_n_o && !prev_ss) rises <= rises + 1;
        end
        prev_sclk <= sclk_o;
        prev_mosi <= mosi_o;
        prev_ss   <= ss_n_o;
    end

    // Watchdog: a hung run counts as a failure and still prints the summary.
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000 && !finished) begin
            finished = 1;
            errors = errors + 1;
            checks = checks + 1;
            $display("FAIL watchdog actual=%0d expected=<150000 cycles", cyc);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic [7:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = 1'b0; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic a, output logic [7:0] d);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic do_reset(input logic m, input logic pol, input logic pha, input logic [1:0] dv);
        @(negedge clk);
        rst_n = 1'b0;
        cfg_master = m; cfg_cpol = pol; cfg_cpha = pha; cfg_div = dv;
        sclk_i = pol; ss_n_i = 1'b1; cfg_txie = 1'b1; cfg_rxie = 1'b1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        clr_mon = 1'b1;
        @(negedge clk);
        clr_mon = 1'b0;
    endtask

    task automatic wait_rx();
        int n = 0;
        while (!irq_rx && n < 3000) begin @(negedge clk); n++; end
        if (n >= 3000) chk("R8 timeout waiting for receive-full", 0, 1);
    endtask

    task automatic wait_idle();
        int n = 0;
        repeat (2) @(negedge clk);
        while (!ss_n_o && n < 3000) begin @(negedge clk); n++; end
        repeat (2) @(negedge clk);
    endtask

    function automatic int half_tb(input logic [1:0] d);
        int ratio;
        case (d)
            2'd0: ratio = 2;
            2'd1: ratio = 8;
            2'd2: ratio = 16;
            default: ratio = 32;
        endcase
        return ratio / 2;
    endfunction

    task automatic slave_xfer(input logic [7:0] m, output logic [7:0] got);
        for (int i = 7; i >= 0; i--) begin
            if (!cfg_cpha) begin
                mosi_i = m[i];
                repeat (H) @(negedge clk);
                got[i] = miso_o;
                sclk_i = ~cfg_cpol;
                repeat (H) @(negedge clk);
                sclk_i = cfg_cpol;
            end else begin
                sclk_i = ~cfg_cpol;
                mosi_i = m[i];
                repeat (H) @(negedge clk);
                got[i] = miso_o;
                sclk_i = cfg_cpol;
                repeat (H) @(negedge clk);
            end
        end
    endtask

    initial begin
        logic [7:0] rd, b, g1, g2, g3;

        // R1: reset state
        do_reset(1'b1, 1'b1, 1'b0, 2'd0);
        bus_read(1'b1, rd);
        chk("R1 status after reset", rd, 8'h01);
        chk("R1 select idle", ss_n_o, 1);
        chk("R1 clock at polarity", sclk_o, 1);
        chk("R11 irq_tx after reset", irq_tx, 1);
        chk("R11 irq_rx after reset", irq_rx, 0);

        // R3 R4 R8 R9: master sweep over polarity, phase and divider
        for (int m = 0; m < 16; m++) begin
            b = 8'(8'h5A ^ (m * 29));
            do_reset(1'b1, m[0], m[1], 2'(m >> 2));
            bus_write(b);
            wait_rx();
            repeat (2) @(negedge clk);
            chk("R4 select-low cycles", lowcnt, 16 * half_tb(2'(m >> 2)));
            chk("R4 single select window", rises, 1);
            chk("R4 clock idle level", sclk_o, m[0]);
            chk("R3 MSB-first MOSI", cap, b);
            bus_read(1'b1, rd);
            chk("R8 status receive-full", rd, 8'h03);
            bus_read(1'b0, rd);
            chk("R3 received byte", rd, b);
            bus_read(1'b1, rd);
            chk("R9 cleared after sequence", rd, 8'h01);
        end

        // R2 R5: two bytes queued back to back
        do_reset(1'b1, 1'b0, 1'b1, 2'd1);
        bus_write(8'h3C);
        chk("R2 empty cleared by write", irq_tx, 0);
        @(negedge clk);
        chk("R2 empty set two cycles after write", irq_tx, 1);
        bus_write(8'hE1);
        chk("R5 second byte held", irq_tx, 0);
        wait_rx();
        chk("R5 empty set when second byte moves", irq_tx, 1);
        bus_read(1'b1, rd);
        bus_read(1'b0, rd);
        chk("R5 first byte", rd, 8'h3C);
        wait_rx();
        repeat (2) @(negedge clk);
        chk("R5 select low for both bytes", lowcnt, 32 * 4);
        chk("R5 no select gap", rises, 1);
        bus_read(1'b1, rd);
        bus_read(1'b0, rd);
        chk("R5 second byte", rd, 8'hE1);

        // R10: overrun when the first byte is left unread
        do_reset(1'b1, 1'b0, 1'b1, 2'd1);
        bus_write(8'h81);
        @(negedge clk);
        bus_write(8'h7E);
        wait_rx();
        wait_idle();
        bus_read(1'b1, rd);
        chk("R10 status overrun", rd, 8'h07);
        bus_read(1'b0, rd);
        chk("R10 first byte kept", rd, 8'h81);
        bus_read(1'b1, rd);
        chk("R10 overrun cleared by sequence", rd, 8'h01);

        // R9: a data read alone does not clear receive-full
        do_reset(1'b1, 1'b1, 1'b1, 2'd0);
        bus_write(8'hA7);
        wait_rx();
        bus_read(1'b0, rd);
        chk("R9 data without status", rd, 8'hA7);
        chk("R9 still full", irq_rx, 1);
        bus_read(1'b1, rd);
        chk("R9 status shows full", rd, 8'h03);
        bus_read(1'b0, rd);
        @(negedge clk);
        chk("R9 cleared", irq_rx, 0);

        // R11: interrupt enables gate the requests
        do_reset(1'b1, 1'b0, 1'b0, 2'd0);
        cfg_rxie = 1'b0;
        bus_write(8'h42);
        wait_idle();
        chk("R11 irq_rx masked", irq_rx, 0);
        cfg_rxie = 1'b1;
        #1 chk("R11 irq_rx enabled", irq_rx, 1);
        cfg_txie = 1'b0;
        #1 chk("R11 irq_tx masked", irq_tx, 0);

        // R6 R7 R12: slave mode in all four modes
        for (int m = 0; m < 4; m++) begin
            do_reset(1'b0, m[0], m[1], 2'd0);
            bus_write(8'(8'hC3 ^ (m * 17)));
            @(negedge clk);
            chk("R2 slave idle load", irq_tx, 1);
            ss_n_i = 1'b0;
            repeat (4) @(negedge clk);
            fork
                slave_xfer(8'(8'h96 ^ m), g1);
                begin
                    repeat (40) @(negedge clk);
                    bus_write(8'(8'h2D + m));
                    repeat (3) @(negedge clk);
                    chk("R6 empty stays low mid-byte", irq_tx, 0);
                end
            join
            repeat (5) @(negedge clk);
            chk("R6 empty after byte end", irq_tx, 1);
            chk("R12 first slave byte MSB first", g1, 8'(8'hC3 ^ (m * 17)));
            bus_read(1'b1, rd);
            bus_read(1'b0, rd);
            chk("R8 slave received byte", rd, 8'(8'h96 ^ m));
            slave_xfer(8'(8'h61 ^ (m * 5)), g2);
            repeat (5) @(negedge clk);
            chk("R12 queued slave byte", g2, 8'(8'h2D + m));
            bus_read(1'b1, rd);
            bus_read(1'b0, rd);
            chk("R12 slave second received", rd, 8'(8'h61 ^ (m * 5)));
            slave_xfer(8'h0F, g3);
            repeat (5) @(negedge clk);
            chk("R7 resend of shift contents", g3, 8'(8'h61 ^ (m * 5)));
            bus_read(1'b1, rd);
            bus_read(1'b0, rd);
            chk("R8 slave third received", rd, 8'h0F);
            ss_n_i = 1'b1;
        end

        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule